// File: doc/BRIEF.md
# Software Write-Protection Sequencer

This block sits in front of the array of a small parallel non-volatile memory. It watches each qualified byte write, which is one address and one data byte, and decides whether that write may be committed to the array. It also keeps a flag that tells whether software write protection is active. The array itself and its programming timing belong to other blocks.

After reset, protection is off and every write goes through. Three command writes in a set order turn protection on. The same three writes open a load window, and data writes are committed only while that window is open. Each accepted data write restarts the window. If the window runs out, the block falls back to protected idle. In that state any write that does not follow the three-write prefix is dropped. A separate six-write command string turns protection off again. A write that does not fit the expected step aborts the current sequence. If the aborting write is the first command byte, the sequence starts again from step one.

Top module: `sdp_sequencer`

## Requirements
- R1: After reset, `protected_o` is 0. While `protected_o` is 0, every write with `wr_valid` high has `commit_o` high in the same cycle.
- R2: The arming prefix is three writes in this order: data 8'hAA at address 13'h1555, then 8'h55 at 13'h0AAA, then 8'hA0 at 13'h1555. `protected_o` reads 1 from the clock edge that accepts the third write. This holds even if no data write follows.
- R3: While protection is off, the command writes themselves are committed like any other write.
- R4: After the prefix, a data write to any address is committed when it arrives no more than `WINDOW_CYC` cycles after the previous accepted write. Each accepted data write restarts the window.
- R5: A write that arrives later than `WINDOW_CYC` cycles after the previous one is not committed. `protected_o` stays 1.
- R6: While protected, a write that is not preceded by the arming prefix has `commit_o` low.
- R7: While protected, the command writes of any sequence have `commit_o` low.
- R8: The disarm string is six writes in order: AA@1555h, 55@0AAAh, 80@1555h, AA@1555h, 55@0AAAh, 20@1555h. None of these writes is committed while protected. `protected_o` reads 0 from the edge that accepts the sixth write, and the next write is committed.
- R9: A write that does not match both the address and the data of the next expected step aborts the sequence. If that write is AA@1555h, it counts as step one of a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A qualified byte write is presented this cycle |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data byte of the write |
| commit_o | output | 1 | The presented write may be committed to the array (same cycle) |
| protected_o | output | 1 | Software write protection is active |

## Verification
The bench aims at both edges of the load window. A write exactly `WINDOW_CYC` cycles after the previous one must commit. A write one cycle later must be dropped. A timer that is off by one would either shut out the last legal write or let a late one through. An aborted sequence is checked twice: once with a wrong address and correct data, and once where the first command byte is repeated. A design that ignored address bits would arm when it should not. A design that sent every abort straight to idle would miss the restarted prefix. Command writes are checked in both modes. A design that gated commits by sequence step instead of by protection state would drop them when unprotected, or write them when protected. A disarm string with a wrong final byte must leave protection on.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_P1   = 3'd1,
      ST_P2   = 3'd2,
      ST_LOAD = 3'd3,
      ST_D3   = 3'd4,
      ST_D4   = 3'd5,
      ST_D5   = 3'd6
   } sdp_state_e;

   localparam int unsigned CMD_ADDR_W = 13;
   localparam int unsigned CMD_NUM    = 5;

   // index of each recognised command word inside the match vector
   localparam int unsigned C_AA = 0;
   localparam int unsigned C_55 = 1;
   localparam int unsigned C_A0 = 2;
   localparam int unsigned C_80 = 3;
   localparam int unsigned C_20 = 4;

   function automatic logic [CMD_ADDR_W-1:0] cmd_addr(input int unsigned idx);
      case (idx)
         C_55:    cmd_addr = 13'h0AAA;
         default: cmd_addr = 13'h1555;
      endcase
   endfunction

   function automatic logic [7:0] cmd_data(input int unsigned idx);
      case (idx)
         C_AA:    cmd_data = 8'hAA;
         C_55:    cmd_data = 8'h55;
         C_A0:    cmd_data = 8'hA0;
         C_80:    cmd_data = 8'h80;
         default: cmd_data = 8'h20;
      endcase
   endfunction

endpackage

// File: rtl/sdp_cmd_match.sv
module sdp_cmd_match #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [sdp_pkg::CMD_NUM-1:0] hit
);
   import sdp_pkg::*;

   generate
      if (ADDR_W < CMD_ADDR_W) begin : g_bad_addr
         $error("sdp_cmd_match: ADDR_W must be at least 13");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("sdp_cmd_match: DATA_W must be 8");
      end
   endgenerate

   // one comparator per command word; upper address bits must be zero
   generate
      for (genvar i = 0; i < CMD_NUM; i++) begin : g_cmp
         localparam logic [ADDR_W-1:0] A_REF = ADDR_W'(cmd_addr(i));
         localparam logic [DATA_W-1:0] D_REF = DATA_W'(cmd_data(i));
         assign hit[i] = (wr_addr == A_REF) && (wr_data == D_REF);
      end
   endgenerate

endmodule

// File: rtl/sdp_window_timer.sv
module sdp_window_timer #(
   parameter int unsigned WINDOW_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic run,
   output logic last
);
   localparam int unsigned CNT_W = $clog2(WINDOW_CYC + 1);

   generate
      if (WINDOW_CYC < 1) begin : g_bad_win
         $error("sdp_window_timer: WINDOW_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (reload)                 cnt_q <= CNT_W'(WINDOW_CYC);
      else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   // the cycle in which no write arrives and the window closes
   assign last = run && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sdp_fsm.sv
module sdp_fsm (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_valid,
   input  logic [sdp_pkg::CMD_NUM-1:0] hit,
   input  logic                        win_last,
   output logic                        win_reload,
   output logic                        win_run,
   output logic                        commit,
   output logic                        prot,
   output sdp_pkg::sdp_state_e         state
);
   import sdp_pkg::*;

   sdp_state_e st_q, st_d;
   logic       prot_q, prot_d;
   sdp_state_e abort_st;

   assign abort_st = hit[C_AA] ? ST_P1 : ST_IDLE;

   always_comb begin
      st_d       = st_q;
      prot_d     = prot_q;
      win_reload = 1'b0;
      if (wr_valid) begin
         unique case (st_q)
            ST_IDLE: st_d = hit[C_AA] ? ST_P1 : ST_IDLE;
            ST_P1:   st_d = hit[C_55] ? ST_P2 : abort_st;
            ST_P2: begin
               if (hit[C_A0]) begin
                  st_d       = ST_LOAD;
                  prot_d     = 1'b1;
                  win_reload = 1'b1;
               end else if (hit[C_80]) begin
                  st_d = ST_D3;
               end else begin
                  st_d = abort_st;
               end
            end
            ST_LOAD: win_reload = 1'b1;
            ST_D3:   st_d = hit[C_AA] ? ST_D4 : abort_st;
            ST_D4:   st_d = hit[C_55] ? ST_D5 : abort_st;
            ST_D5: begin
               if (hit[C_20]) begin
                  st_d   = ST_IDLE;
                  prot_d = 1'b0;
               end else begin
                  st_d = abort_st;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end else if (st_q == ST_LOAD && win_last) begin
         st_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         prot_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         prot_q <= prot_d;
      end
   end

   assign win_run = (st_q == ST_LOAD);
   assign commit  = wr_valid && (!prot_q || st_q == ST_LOAD);
   assign prot    = prot_q;
   assign state   = st_q;

endmodule

// File: rtl/sdp_sequencer.sv
module sdp_sequencer #(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WINDOW_CYC = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              commit_o,
   output logic              protected_o
);
   import sdp_pkg::*;

   logic [CMD_NUM-1:0] hit;
   logic               win_last, win_reload, win_run;
   sdp_state_e         fsm_state;

   sdp_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hit     (hit)
   );

   sdp_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (win_reload),
      .run    (win_run),
      .last   (win_last)
   );

   sdp_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .hit        (hit),
      .win_last   (win_last),
      .win_reload (win_reload),
      .win_run    (win_run),
      .commit     (commit_o),
      .prot       (protected_o),
      .state      (fsm_state)
   );

endmodule

// File: rtl/sdp_sequencer_chk.sv
module sdp_sequencer_chk #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_valid,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic                commit_o,
   input logic                protected_o,
   input sdp_pkg::sdp_state_e fsm_state
);
   import sdp_pkg::*;

   logic w_a0, w_20;
   assign w_a0 = wr_valid && wr_addr == ADDR_W'(13'h1555) && wr_data == DATA_W'(8'hA0);
   assign w_20 = wr_valid && wr_addr == ADDR_W'(13'h1555) && wr_data == DATA_W'(8'h20);

   p_unprot_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!protected_o && wr_valid) |-> commit_o);

   p_commit_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> wr_valid);

   p_arm_sets_prot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_P2 && w_a0) |=> protected_o);

   p_disarm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_D5 && w_20) |=> !protected_o);

   p_cmd_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (protected_o && wr_valid && fsm_state != ST_LOAD) |-> !commit_o);

   p_prot_moves_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (protected_o != $past(protected_o)) |-> $past(wr_valid));

endmodule

bind sdp_sequencer sdp_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .commit_o    (commit_o),
   .protected_o (protected_o),
   .fsm_state   (fsm_state)
);

// File: tb/tb_sdp_sequencer.sv
module tb_sdp_sequencer;
   localparam int unsigned WIN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [12:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        commit_o, protected_o;
   int          n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   sdp_sequencer #(.ADDR_W(13), .DATA_W(8), .WINDOW_CYC(WIN)) dut (
      .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .commit_o, .protected_o
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   // one write; commit sampled before the edge that takes it
   task automatic wr(input logic [12:0] a, input logic [7:0] d, output logic c);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      #1 c = commit_o;
      @(posedge clk);
      #1 wr_valid = 1'b0;
   endtask

   task automatic gap(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic c;
      check("R1 flag at reset", protected_o, 1'b0);
      wr(13'h0003, 8'h12, c);
      check("R1 plain write commits", c, 1'b1);
   endtask

   task automatic t_arm_unprot();
      logic c;
      wr(13'h1555, 8'hAA, c); check("R3 cmd1 commits", c, 1'b1);
      wr(13'h0AAA, 8'h55, c); check("R3 cmd2 commits", c, 1'b1);
      check("R2 not yet protected", protected_o, 1'b0);
      wr(13'h1555, 8'hA0, c); check("R3 cmd3 commits", c, 1'b1);
      check("R2 protected after prefix", protected_o, 1'b1);
      wr(13'h0100, 8'h11, c); check("R4 data at once", c, 1'b1);
      gap(WIN - 1);
      wr(13'h0101, 8'h22, c); check("R4 data at window edge", c, 1'b1);
      gap(WIN);
      wr(13'h0102, 8'h33, c); check("R5 late write dropped", c, 1'b0);
      check("R5 still protected", protected_o, 1'b1);
   endtask

   task automatic t_blocked();
      logic c;
      wr(13'h0200, 8'h44, c); check("R6 unprefixed write", c, 1'b0);
   endtask

   task automatic t_arm_prot();
      logic c;
      wr(13'h1555, 8'hAA, c); check("R7 cmd1 blocked", c, 1'b0);
      wr(13'h0AAA, 8'h55, c); check("R7 cmd2 blocked", c, 1'b0);
      wr(13'h1555, 8'hA0, c); check("R7 cmd3 blocked", c, 1'b0);
      wr(13'h1555, 8'hAA, c); check("R4 data in window", c, 1'b1);
      gap(WIN + 2);
   endtask

   task automatic t_abort();
      logic c;
      wr(13'h1555, 8'hAA, c);
      wr(13'h0555, 8'h55, c); check("R9 wrong address blocked", c, 1'b0);
      wr(13'h1555, 8'hA0, c);
      wr(13'h0300, 8'h66, c); check("R9 no arm after abort", c, 1'b0);
      wr(13'h1555, 8'hAA, c);
      wr(13'h1555, 8'hAA, c); check("R9 restart cmd blocked", c, 1'b0);
      wr(13'h0AAA, 8'h55, c);
      wr(13'h1555, 8'hA0, c);
      wr(13'h0301, 8'h77, c); check("R9 restarted prefix arms", c, 1'b1);
      gap(WIN + 2);
   endtask

   task automatic t_disarm(input logic [7:0] last_d, input logic expect_off);
      logic c;
      logic any;
      any = 1'b0;
      wr(13'h1555, 8'hAA, c); any |= c;
      wr(13'h0AAA, 8'h55, c); any |= c;
      wr(13'h1555, 8'h80, c); any |= c;
      wr(13'h1555, 8'hAA, c); any |= c;
      wr(13'h0AAA, 8'h55, c); any |= c;
      check("R8 still protected before last", protected_o, 1'b1);
      wr(13'h1555, last_d, c); any |= c;
      check("R8 no command committed", any, 1'b0);
      check("R8 flag after string", protected_o, !expect_off);
      wr(13'h0400, 8'h88, c); check("R8 next write", c, expect_off);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_arm_unprot();
      t_blocked();
      t_arm_prot();
      t_abort();
      t_disarm(8'h21, 1'b0);
      t_disarm(8'h20, 1'b1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule